// File: doc/BRIEF.md
# Wrapping Cacheline Responder

This block answers a cache controller over two first-in-first-out links. Commands arrive on an access queue: each entry carries a control flag and a 32-bit word. The block decodes these entries and serves them against a small internal word-addressed store. Results go out on a read-data queue, and each returned word carries its own valid flag.

A line read returns a whole cacheline. The first word returned is the one that was asked for. The words after it follow in ascending order and wrap inside the line's aligned block. A single-word write takes two access entries, an address entry and then a data entry, and it produces no response. A read whose address lies outside the store still returns a full line, but every word is flagged invalid and its data is zero.

The block stops building a line while the read-data queue is full. While it is busy with a line it also stops draining the access queue, so backpressure reaches the producer through the access queue's full flag.

Top module: `cl_line_slave`

## Requirements
- R1: For a line read, the first word delivered is the word stored at the requested word address, whatever that address's offset within its line.
- R2: A line read delivers exactly LINE_WORDS words. Word k comes from address (A with its low log2(LINE_WORDS) bits cleared) plus ((A + k) mod LINE_WORDS), where A is the requested word address.
- R3: Every word of a line read whose address is below MEM_WORDS is delivered with rd_ctl = 1.
- R4: A line read whose word address is MEM_WORDS or above delivers LINE_WORDS words, each with rd_ctl = 0 and rd_data = 0.
- R5: An access entry with acc_ctl = 1 and data bit 0 = 1, followed by an entry with acc_ctl = 0, writes the second entry's 32-bit data to the addressed word. The write produces no read-data output.
- R6: A write whose word address is MEM_WORDS or above leaves the store unchanged, including the word that shares its low address bits.
- R7: An acc_ctl = 0 entry that arrives with no write address pending is discarded. It changes no stored word and produces no output.
- R8: acc_full is 1 exactly when the access queue holds QDEPTH entries. No entry written while acc_full is 0 is lost.
- R9: rd_exists is 1 while the read-data queue is non-empty. A word is removed on a cycle where rd_read and rd_exists are both 1, and the word at the head holds steady until it is removed. Line generation stalls while the queue is full, and no word is dropped.
- R10: After reset, both queues are empty, and store word i holds 32'hC0DE0000 + i.
- R11: In an address entry, bits 31:2 hold the word address, bit 0 selects the operation (0 = line read, 1 = single write), and bit 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_write | input | 1 | Push one entry into the access queue |
| acc_ctl | input | 1 | Entry flag: 1 = address entry, 0 = data entry |
| acc_data | input | 32 | Entry word |
| acc_full | output | 1 | Access queue holds QDEPTH entries |
| rd_read | input | 1 | Remove the head word of the read-data queue |
| rd_ctl | output | 1 | Head word flag: 1 = valid, 0 = error |
| rd_data | output | 32 | Head word data |
| rd_exists | output | 1 | Read-data queue is non-empty |

## Verification
A line read is issued at every start address in the store. This separates correct wrapping from linear or aligned ordering, because every offset inside a line gets its own expected order. Writing a distinct value to every word and then sweeping the reads again shows that writes land at the right address, and that no read is served from the reset pattern. The out-of-range reads and writes, the stray data entries and the ignored bit 1 each target one branch of the address decode. In the final phase the consumer stays idle until both queues are full. This shows that the access queue flags full at exactly QDEPTH entries and that no word is lost while line generation is stalled.

// File: rtl/cl_pkg.sv
package cl_pkg;

    localparam int DATA_W = 32;
    localparam int FA_W   = DATA_W - 2;

    typedef struct packed {
        logic              ctl;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_DATA,
        ST_LINE
    } state_t;

    function automatic logic [DATA_W-1:0] init_word(input int unsigned i);
        return {16'hC0DE, i[15:0]};
    endfunction

endpackage

// File: rtl/cl_fifo.sv
module cl_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/cl_store.sv
module cl_store
    import cl_pkg::*;
#(
    parameter int MEM_WORDS = 16,
    parameter int AW        = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [MEM_WORDS];

    assign rdata = words[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) words[i] <= init_word(i);
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/cl_ctrl.sv
module cl_ctrl
    import cl_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    parameter int MEM_WORDS  = 16,
    parameter int AW         = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_empty,
    input  word_t             acc_head,
    output logic              acc_pop,
    input  logic              rdq_full,
    output logic              rdq_push,
    output word_t             rdq_din,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [AW-1:0]     mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int           OFF_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam logic [AW-1:0] MASK = AW'(LINE_WORDS - 1);

    state_t           state;
    logic [AW-1:0]    base;
    logic [OFF_W-1:0] idx;
    logic             ok;

    logic [FA_W-1:0]  head_wa;
    logic             head_in;
    logic [AW-1:0]    cur;

    assign head_wa = acc_head.data[DATA_W-1:2];
    assign head_in = head_wa < FA_W'(MEM_WORDS);

    // critical word first, wrapping inside the aligned line
    assign cur       = (base & ~MASK) | ((base + AW'(idx)) & MASK);
    assign mem_raddr = cur;

    assign acc_pop  = (state != ST_LINE) && !acc_empty;
    assign rdq_push = (state == ST_LINE) && !rdq_full;

    always_comb begin
        rdq_din.ctl  = ok;
        rdq_din.data = ok ? mem_rdata : '0;
    end

    assign mem_we    = (state == ST_WAIT_DATA) && acc_pop && !acc_head.ctl && ok;
    assign mem_waddr = base;
    assign mem_wdata = acc_head.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            base  <= '0;
            idx   <= '0;
            ok    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_WAIT_DATA: begin
                    if (acc_pop) begin
                        if (acc_head.ctl) begin
                            base  <= head_wa[AW-1:0];
                            ok    <= head_in;
                            idx   <= '0;
                            state <= acc_head.data[0] ? ST_WAIT_DATA : ST_LINE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_LINE: begin
                    if (rdq_push) begin
                        idx <= idx + 1'b1;
                        if (idx == OFF_W'(LINE_WORDS - 1)) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cl_line_slave.sv
module cl_line_slave
    import cl_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    parameter int MEM_WORDS  = 16,
    parameter int QDEPTH     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_write,
    input  logic        acc_ctl,
    input  logic [31:0] acc_data,
    output logic        acc_full,
    input  logic        rd_read,
    output logic        rd_ctl,
    output logic [31:0] rd_data,
    output logic        rd_exists
);
    localparam int AW = $clog2(MEM_WORDS);
    localparam int WW = $bits(word_t);

    word_t             acc_in, acc_head, rdq_din, rd_head;
    logic              acc_empty, acc_pop;
    logic              rdq_push, rdq_full, rdq_empty;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    assign acc_in.ctl  = acc_ctl;
    assign acc_in.data = acc_data;

    cl_fifo #(.WIDTH(WW), .DEPTH(QDEPTH)) u_accq (
        .clk(clk), .rst(rst),
        .push(acc_write), .din(acc_in),
        .pop(acc_pop), .dout(acc_head),
        .full(acc_full), .empty(acc_empty)
    );

    cl_ctrl #(.LINE_WORDS(LINE_WORDS), .MEM_WORDS(MEM_WORDS), .AW(AW)) u_ctrl (
        .clk(clk), .rst(rst),
        .acc_empty(acc_empty), .acc_head(acc_head), .acc_pop(acc_pop),
        .rdq_full(rdq_full), .rdq_push(rdq_push), .rdq_din(rdq_din),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    cl_store #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_store (
        .clk(clk), .rst(rst),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    cl_fifo #(.WIDTH(WW), .DEPTH(QDEPTH)) u_rdq (
        .clk(clk), .rst(rst),
        .push(rdq_push), .din(rdq_din),
        .pop(rd_read), .dout(rd_head),
        .full(rdq_full), .empty(rdq_empty)
    );

    assign rd_ctl    = rd_head.ctl;
    assign rd_data   = rd_head.data;
    assign rd_exists = !rdq_empty;
endmodule

// File: rtl/cl_line_slave_chk.sv
module cl_line_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_full,
    input logic        acc_pop,
    input logic        rd_read,
    input logic        rd_ctl,
    input logic [31:0] rd_data,
    input logic        rd_exists,
    input logic        rdq_push,
    input logic        rdq_full
);
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(rdq_push && rdq_full));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_exists && !rd_read) |=> (rd_exists && $stable(rd_data) && $stable(rd_ctl)));

    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_exists && !rd_ctl) |-> (rd_data == 32'd0));

    // R10
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rd_exists && !acc_full));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_full && !acc_pop) |=> acc_full);
endmodule

bind cl_line_slave cl_line_slave_chk u_chk (
    .clk(clk), .rst(rst), .acc_full(acc_full), .acc_pop(acc_pop),
    .rd_read(rd_read), .rd_ctl(rd_ctl), .rd_data(rd_data),
    .rd_exists(rd_exists), .rdq_push(rdq_push), .rdq_full(rdq_full)
);

// File: tb/test_cl_line_slave.sv
`timescale 1ns/1ps
module test_cl_line_slave;
    localparam int L = 4;
    localparam int M = 16;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_write = 1'b0;
    logic        acc_ctl = 1'b0;
    logic [31:0] acc_data = '0;
    logic        acc_full;
    logic        rd_read = 1'b0;
    logic        rd_ctl;
    logic [31:0] rd_data;
    logic        rd_exists;

    int total = 0;
    int bad   = 0;

    logic [31:0] model [M];
    logic [32:0] expq [1024];
    int          eh = 0;
    int          et = 0;

    always #2.5 clk = ~clk;

    cl_line_slave #(.LINE_WORDS(L), .MEM_WORDS(M), .QDEPTH(D)) i_cl_line_slave (
        .clk(clk), .rst(rst), .acc_write(acc_write), .acc_ctl(acc_ctl),
        .acc_data(acc_data), .acc_full(acc_full), .rd_read(rd_read),
        .rd_ctl(rd_ctl), .rd_data(rd_data), .rd_exists(rd_exists)
    );

    task automatic check(input bit ok, input string req,
                         input logic [32:0] act, input logic [32:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic c, input logic [31:0] d);
        @(negedge clk);
        while (acc_full) @(negedge clk);
        acc_write = 1'b1;
        acc_ctl   = c;
        acc_data  = d;
        @(posedge clk);
        #1 acc_write = 1'b0;
    endtask

    task automatic read_cmd(input int unsigned wa, input logic [1:0] low);
        push_word(1'b1, (wa << 2) | 32'(low & 2'b10));
        for (int k = 0; k < L; k++) begin
            int unsigned a;
            a = (wa & ~(L - 1)) | ((wa + k) & (L - 1));
            if (wa < M) expq[et] = {1'b1, model[a]};
            else        expq[et] = {1'b0, 32'd0};
            et++;
        end
    endtask

    task automatic write_cmd(input int unsigned wa, input logic [31:0] v);
        push_word(1'b1, (wa << 2) | 32'd1);
        push_word(1'b0, v);
        if (wa < M) model[wa] = v;
    endtask

    task automatic drain(input string tag);
        int idle;
        idle = 0;
        while (eh != et && idle < 400) begin
            @(negedge clk);
            if (rd_exists) begin
                check({rd_ctl, rd_data} === expq[eh], tag, {rd_ctl, rd_data}, expq[eh]);
                eh++;
                idle = 0;
                rd_read = 1'b1;
                @(posedge clk);
                #1 rd_read = 1'b0;
            end else begin
                idle++;
            end
        end
        if (eh != et) check(1'b0, {tag, " missing words"}, 33'(et - eh), 33'd0);
        repeat (12) @(negedge clk);
        check(rd_exists == 1'b0, {tag, " no extra output"}, {32'd0, rd_exists}, 33'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < M; i++) model[i] = 32'hC0DE0000 + i;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: queues empty after reset
        check(rd_exists == 1'b0, "R10 rd_exists", {32'd0, rd_exists}, 33'd0);
        check(acc_full == 1'b0, "R10 acc_full", {32'd0, acc_full}, 33'd0);
        // R10: reset contents of the store
        for (int a = 0; a < M; a += L) read_cmd(a, 2'b00);
        drain("R10 reset contents");

        // R1 R2 R3: every start offset
        for (int a = 0; a < M; a++) begin
            read_cmd(a, 2'b00);
            drain("R1 R2 R3 wrap sweep");
        end

        // R11: bit 1 of the address entry is ignored
        read_cmd(5, 2'b10);
        drain("R11 bit1 ignored");

        // R5: write every word with a distinct value, then read all offsets
        for (int a = 0; a < M; a++) write_cmd(a, 32'h12340000 ^ (a * 32'h9E3779B9));
        drain("R5 write silent");
        for (int a = 0; a < M; a++) read_cmd(a, 2'b00);
        drain("R5 written data");

        // R4: out-of-range reads
        read_cmd(M, 2'b00);
        read_cmd(M + 1, 2'b00);
        read_cmd(1000, 2'b00);
        read_cmd(32'h2000_0000, 2'b00);
        drain("R4 out of range read");

        // R6: out-of-range write aliasing word 3 must not change it
        write_cmd(M + 3, 32'hBADBAD00);
        read_cmd(3, 2'b00);
        drain("R6 out of range write");

        // R7: stray data entries are dropped
        push_word(1'b0, 32'hDEAD0001);
        push_word(1'b0, 32'hDEAD0002);
        read_cmd(0, 2'b00);
        read_cmd(3, 2'b00);
        drain("R7 stray data");

        // R8 R9: idle consumer, fill both queues
        for (int n = 0; n < D + 5; n++) read_cmd(n % M, 2'b00);
        repeat (40) @(negedge clk);
        check(acc_full == 1'b1, "R8 full at depth", {32'd0, acc_full}, 33'd1);
        check(rd_exists == 1'b1, "R9 exists while stalled", {32'd0, rd_exists}, 33'd1);
        drain("R9 no loss under stall");
        check(acc_full == 1'b0, "R8 full cleared", {32'd0, acc_full}, 33'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule